// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the two error counters of a CAN node, one for transmit errors and one for receive errors. From their values it works out the node's confinement state: error active, error passive or bus off. A separate bit-level engine detects the protocol events and presents each one as a single-cycle pulse. The block turns those pulses into counter steps and follows the protocol's increment and decrement rules, including the exceptions for the transmit error flag and the clamp on a successful reception.

A transmit step that would take the counter to 256 or beyond makes the node bus off. The node then enters a reset mode that only software can leave. Once software has left it, the node counts strobes that each mark eleven recessive bits seen on the bus. After enough of them it rejoins the bus with both counters at zero. Each of these transitions gives a one-cycle interrupt pulse when interrupts are enabled. A warning output reports a heavily disturbed bus.

Top module: `can_fault_confine`

## Requirements
- R1: After reset the transmit counter and the receive counter are both 0. The state is error active (code 2'b00). Warning, reset mode and both interrupt outputs are 0. Every output is registered: an event pulse sampled at one clock edge shows on the outputs right after that edge.
- R2: The receive counter adds 1 for a receiver error. It adds 8 for each of these: a bit error during the node's own active error or overload flag (this replaces the +1 when both arrive together), a dominant first bit after an error flag, and an extra-dominant-bits penalty. Pulses in the same cycle add up, and the counter saturates at 255.
- R3: The transmit counter adds 8 for an error flag sent. No step is taken when the arbitration-stuff qualifier is set. No step is taken when the passive-ACK qualifier is set while the node is error passive; that qualifier has no effect while the node is error active. A bit error during an active or overload flag adds 8, and so does the extra-dominant-bits penalty. Pulses in the same cycle add up.
- R4: A successful transmission lowers the transmit counter by 1. It stays at 0 when it is already 0.
- R5: A successful reception lowers the receive counter by 1 when it is between 1 and 127. It leaves it at 0 when it is 0. It sets it to 127 when it is above 127.
- R6: When any increment reaches a counter in a cycle, the decrement for that same counter in that cycle is dropped.
- R7: The state output is error passive (2'b01) when either counter is 128 or more. It is error active when both are 127 or less. It is bus off (2'b10) while the node is bus off.
- R8: A transmit step that would bring the counter to 256 or more enters bus off. The transmit counter loads 127, the receive counter clears and reset mode sets. The bus-off interrupt pulses for exactly one cycle if irq_en is 1, and stays 0 otherwise.
- R9: While bus off, all error and success pulses are ignored and both counters hold.
- R10: While reset mode is 1, eleven-recessive strobes are not counted. A pulse on rm_clear_i clears reset mode.
- R11: After reset mode is cleared, the 128th eleven-recessive strobe sets both counters to 0 and returns the node to error active. The recovery interrupt pulses for one cycle if irq_en is 1.
- R12: The warning output is 1 exactly when either counter is above 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 1 | Enables the two interrupt pulses |
| rx_err_i | input | 1 | Receiver detected an error |
| rx_flag_biterr_i | input | 1 | Receiver bit error during its own active error or overload flag |
| rx_dom_after_flag_i | input | 1 | First bit after the receiver's error flag was dominant |
| rx_extra_dom_i | input | 1 | Extra-dominant-bits penalty while receiving |
| tx_flag_i | input | 1 | Transmitter sent an error flag |
| tx_exc_ack_i | input | 1 | Flag caused by an ACK error with no dominant bit seen during a passive flag |
| tx_exc_arb_i | input | 1 | Flag caused by a stuff error on a recessive arbitration bit read back dominant |
| tx_flag_biterr_i | input | 1 | Transmitter bit error during an active error or overload flag |
| tx_extra_dom_i | input | 1 | Extra-dominant-bits penalty while transmitting |
| tx_ok_i | input | 1 | Message transmitted successfully |
| rx_ok_i | input | 1 | Message received successfully |
| idle11_i | input | 1 | Eleven consecutive recessive bits seen |
| rm_clear_i | input | 1 | Software clears reset mode |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| node_state_o | output | 2 | 00 error active, 01 error passive, 10 bus off |
| warn_o | output | 1 | Heavy-disturbance warning |
| reset_mode_o | output | 1 | Reset mode held after bus off |
| busoff_irq_o | output | 1 | One-cycle pulse on bus-off entry |
| recover_irq_o | output | 1 | One-cycle pulse on bus-off recovery |

## Verification
The assertions watch properties that hold on every cycle:
- the state matches the counter limits;
- bus-off entry always leaves the counters at 127 and 0 with reset mode set;
- a counter held by bus off does not move;
- reset mode keeps the node bus off;
- a saturated receive counter does not wrap;
- each interrupt lasts a single cycle.

Only the bench scenarios can show the exact arithmetic. This includes the exception qualifiers depending on the current state, the +8 that replaces the +1, the clamp to 127, dropped decrements, the warning threshold at 96 versus 97, and the recovery landing on the 128th strobe and not on the 127th.

// File: rtl/fc_pkg.sv
package fc_pkg;

  localparam int TEC_W = 9;
  localparam int REC_W = 8;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUSOFF  = 2'b10
  } node_st_e;

  // Unsaturated transmit sum: current value plus units times the flag step.
  function automatic logic [TEC_W:0] tec_raw(input logic [TEC_W-1:0] cur,
                                             input logic [1:0]        units,
                                             input logic [4:0]        step);
    return {1'b0, cur} +
           ({{(TEC_W-1){1'b0}}, units} * {{(TEC_W-4){1'b0}}, step});
  endfunction

  // Receive sum with saturation at the all-ones value.
  function automatic logic [REC_W-1:0] rec_add_sat(input logic [REC_W-1:0] cur,
                                                   input logic [1:0]        units,
                                                   input logic              one,
                                                   input logic [4:0]        step);
    logic [REC_W+1:0] s;
    s = {2'b00, cur} +
        ({{REC_W{1'b0}}, units} * {{(REC_W-3){1'b0}}, step}) +
        {{(REC_W+1){1'b0}}, one};
    if (s > {2'b00, {REC_W{1'b1}}}) return {REC_W{1'b1}};
    return s[REC_W-1:0];
  endfunction

  // Receive value after a good message: clamp high values, else step down.
  function automatic logic [REC_W-1:0] rec_good(input logic [REC_W-1:0] cur,
                                                input logic [REC_W-1:0] clamp);
    if (cur > clamp) return clamp;
    if (cur != '0)   return cur - REC_W'(1);
    return cur;
  endfunction

  // Transmit value after a good message: step down, floor at zero.
  function automatic logic [TEC_W-1:0] tec_good(input logic [TEC_W-1:0] cur);
    if (cur != '0) return cur - TEC_W'(1);
    return cur;
  endfunction

endpackage

// File: rtl/fc_tx_ctr.sv
module fc_tx_ctr
  import fc_pkg::*;
#(
  parameter int FLAG_STEP  = 8,
  parameter int BUSOFF_TEC = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             clear,
  input  logic [1:0]       units,
  input  logic             dec,
  output logic [TEC_W-1:0] tec_o,
  output logic             ovf_o
);

  localparam logic [TEC_W:0]   BO_LIM  = (TEC_W+1)'(1 << (TEC_W-1));
  localparam logic [TEC_W-1:0] BO_LOAD = TEC_W'(BUSOFF_TEC);
  localparam logic [4:0]       STEP    = 5'(FLAG_STEP);

  logic [TEC_W-1:0] tec_q;
  logic [TEC_W:0]   sum;
  logic             inc_any;

  always_comb begin
    sum     = tec_raw(tec_q, units, STEP);
    inc_any = (units != 2'b00);
    ovf_o   = !hold && inc_any && (sum >= BO_LIM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tec_q <= '0;
    else if (clear)   tec_q <= '0;
    else if (hold)    tec_q <= tec_q;
    else if (ovf_o)   tec_q <= BO_LOAD;
    else if (inc_any) tec_q <= sum[TEC_W-1:0];
    else if (dec)     tec_q <= tec_good(tec_q);
  end

  assign tec_o = tec_q;

  // R4: a lone success pulse lowers a nonzero count by exactly one
  a_r4_tx_dec_one: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc_any && !hold && !clear && tec_q != '0) |=> (tec_q == $past(tec_q) - TEC_W'(1)));

  // R4: zero stays zero on a lone success pulse
  a_r4_tx_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc_any && !hold && !clear && tec_q == '0) |=> (tec_q == '0));

  // R9: held counter does not move
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clear) |=> $stable(tec_q));

endmodule

// File: rtl/fc_rx_ctr.sv
module fc_rx_ctr
  import fc_pkg::*;
#(
  parameter int FLAG_STEP = 8,
  parameter int REC_CLAMP = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             clear,
  input  logic             one,
  input  logic [1:0]       units,
  input  logic             ok,
  output logic [REC_W-1:0] rec_o
);

  localparam logic [REC_W-1:0] CLAMP = REC_W'(REC_CLAMP);
  localparam logic [4:0]       STEP  = 5'(FLAG_STEP);

  logic [REC_W-1:0] rec_q;
  logic             inc_any;

  assign inc_any = one || (units != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n)       rec_q <= '0;
    else if (clear)   rec_q <= '0;
    else if (hold)    rec_q <= rec_q;
    else if (inc_any) rec_q <= rec_add_sat(rec_q, units, one, STEP);
    else if (ok)      rec_q <= rec_good(rec_q, CLAMP);
  end

  assign rec_o = rec_q;

  // R2: a saturated counter never wraps
  a_r2_rx_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_q == '1 && inc_any && !hold && !clear) |=> (rec_q == '1));

  // R5: a lone success pulse above the clamp lands exactly on the clamp
  a_r5_rx_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !inc_any && !hold && !clear && rec_q > CLAMP) |=> (rec_q == CLAMP));

  // R9: held counter does not move
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clear) |=> $stable(rec_q));

endmodule

// File: rtl/fc_bus_ctrl.sv
module fc_bus_ctrl #(
  parameter int RECOV_OCC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic rm_clear,
  input  logic idle11,
  input  logic irq_en,
  output logic busoff_o,
  output logic rm_o,
  output logic done_o,
  output logic bo_irq_o,
  output logic rc_irq_o
);

  localparam int             RCV_W = $clog2(RECOV_OCC + 1);
  localparam logic [RCV_W-1:0] LAST = RCV_W'(RECOV_OCC - 1);

  logic             bo_q, rm_q, bo_irq_q, rc_irq_q;
  logic [RCV_W-1:0] cnt_q;

  assign done_o = bo_q && !rm_q && idle11 && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bo_q     <= 1'b0;
      rm_q     <= 1'b0;
      cnt_q    <= '0;
      bo_irq_q <= 1'b0;
      rc_irq_q <= 1'b0;
    end else begin
      bo_irq_q <= enter && irq_en;
      rc_irq_q <= done_o && irq_en;
      if (enter) begin
        bo_q  <= 1'b1;
        rm_q  <= 1'b1;
        cnt_q <= '0;
      end else if (bo_q) begin
        if (rm_q) begin
          if (rm_clear) rm_q <= 1'b0;
        end else if (done_o) begin
          bo_q  <= 1'b0;
          cnt_q <= '0;
        end else if (idle11) begin
          cnt_q <= cnt_q + RCV_W'(1);
        end
      end
    end
  end

  assign busoff_o = bo_q;
  assign rm_o     = rm_q;
  assign bo_irq_o = bo_irq_q;
  assign rc_irq_o = rc_irq_q;

  // R10: reset mode keeps the node bus off until software clears it
  a_r10_rm_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_q && rm_q && !rm_clear) |=> (bo_q && rm_q));

  // R8: entry interrupt lasts a single cycle
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    bo_irq_q |=> !bo_irq_q);

  // R11: recovery interrupt lasts a single cycle
  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rc_irq_q |=> !rc_irq_q);

  // R11: leaving bus off only happens with reset mode already cleared
  a_r11_exit_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bo_q) |-> !$past(rm_q));

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import fc_pkg::*;
#(
  parameter int FLAG_STEP   = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int WARN_LIM    = 96,
  parameter int REC_CLAMP   = 127,
  parameter int BUSOFF_TEC  = 127,
  parameter int RECOV_OCC   = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_en,
  input  logic             rx_err_i,
  input  logic             rx_flag_biterr_i,
  input  logic             rx_dom_after_flag_i,
  input  logic             rx_extra_dom_i,
  input  logic             tx_flag_i,
  input  logic             tx_exc_ack_i,
  input  logic             tx_exc_arb_i,
  input  logic             tx_flag_biterr_i,
  input  logic             tx_extra_dom_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             idle11_i,
  input  logic             rm_clear_i,
  output logic [8:0]       tec_o,
  output logic [7:0]       rec_o,
  output logic [1:0]       node_state_o,
  output logic             warn_o,
  output logic             reset_mode_o,
  output logic             busoff_irq_o,
  output logic             recover_irq_o
);

  localparam logic [TEC_W-1:0] T_PASS = TEC_W'(PASSIVE_LIM);
  localparam logic [REC_W-1:0] R_PASS = REC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] T_WARN = TEC_W'(WARN_LIM);
  localparam logic [REC_W-1:0] R_WARN = REC_W'(WARN_LIM);

  // Named internal events
  logic             passive_now;
  logic             tx_flag_counted;
  logic [1:0]       tx_units;
  logic [1:0]       rx_units;
  logic             rx_one;
  logic             enter_bo;
  logic             recov_done;
  logic             busoff;
  logic [TEC_W-1:0] tec;
  logic [REC_W-1:0] rec;
  node_st_e         st;

  assign passive_now     = (tec >= T_PASS) || (rec >= R_PASS);
  assign tx_flag_counted = tx_flag_i && !tx_exc_arb_i && !(tx_exc_ack_i && passive_now);
  assign tx_units        = {1'b0, tx_flag_counted} + {1'b0, tx_flag_biterr_i} +
                           {1'b0, tx_extra_dom_i};
  assign rx_units        = {1'b0, rx_flag_biterr_i} + {1'b0, rx_dom_after_flag_i} +
                           {1'b0, rx_extra_dom_i};
  assign rx_one          = rx_err_i && !rx_flag_biterr_i;

  fc_tx_ctr #(
    .FLAG_STEP (FLAG_STEP),
    .BUSOFF_TEC(BUSOFF_TEC)
  ) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (busoff),
    .clear(recov_done),
    .units(tx_units),
    .dec  (tx_ok_i),
    .tec_o(tec),
    .ovf_o(enter_bo)
  );

  fc_rx_ctr #(
    .FLAG_STEP(FLAG_STEP),
    .REC_CLAMP(REC_CLAMP)
  ) u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (busoff),
    .clear(recov_done || enter_bo),
    .one  (rx_one),
    .units(rx_units),
    .ok   (rx_ok_i),
    .rec_o(rec)
  );

  fc_bus_ctrl #(
    .RECOV_OCC(RECOV_OCC)
  ) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter   (enter_bo),
    .rm_clear(rm_clear_i),
    .idle11  (idle11_i),
    .irq_en  (irq_en),
    .busoff_o(busoff),
    .rm_o    (reset_mode_o),
    .done_o  (recov_done),
    .bo_irq_o(busoff_irq_o),
    .rc_irq_o(recover_irq_o)
  );

  always_comb begin
    if (busoff)           st = ST_BUSOFF;
    else if (passive_now) st = ST_PASSIVE;
    else                  st = ST_ACTIVE;
  end

  assign node_state_o = st;
  assign tec_o        = tec;
  assign rec_o        = rec;
  assign warn_o       = (tec > T_WARN) || (rec > R_WARN);

  // R7: the passive code only appears with a counter at or above the limit
  a_r7_passive_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state_o == 2'b01) |-> (tec_o >= T_PASS || rec_o >= R_PASS));

  // R8: bus-off entry leaves the documented counter values and reset mode
  a_r8_entry_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busoff) |-> (tec_o == TEC_W'(BUSOFF_TEC) && rec_o == '0 && reset_mode_o));

  // R11: recovery leaves both counters cleared and the node active
  a_r11_exit_values: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busoff) |-> (tec_o == '0 && rec_o == '0 && node_state_o == 2'b00));

  // R3: a flag excepted by the arbitration qualifier moves nothing on its own
  a_r3_arb_exception: assert property (@(posedge clk) disable iff (!rst_n)
    (!busoff && tx_flag_i && tx_exc_arb_i && !tx_flag_biterr_i && !tx_extra_dom_i && !tx_ok_i)
      |=> $stable(tec_o));

endmodule

// File: tb/can_fault_confine_bench.sv
module can_fault_confine_bench;

  typedef struct packed {
    logic rx_err, rx_fbit, rx_dom, rx_xdom;
    logic tx_flag, x_ack, x_arb, tx_fbit, tx_xdom;
    logic tx_ok, rx_ok, idle, rmclr;
  } ev_t;

  typedef struct packed {
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] st;
    logic       warn, rm, birq, rirq;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_en = 1'b0;
  ev_t  drv = '0;

  logic [8:0] tec_o;
  logic [7:0] rec_o;
  logic [1:0] node_state_o;
  logic       warn_o, reset_mode_o, busoff_irq_o, recover_irq_o;

  always #4 clk = ~clk;

  can_fault_confine u_can_fault_confine (
    .clk                (clk),
    .rst_n              (rst_n),
    .irq_en             (irq_en),
    .rx_err_i           (drv.rx_err),
    .rx_flag_biterr_i   (drv.rx_fbit),
    .rx_dom_after_flag_i(drv.rx_dom),
    .rx_extra_dom_i     (drv.rx_xdom),
    .tx_flag_i          (drv.tx_flag),
    .tx_exc_ack_i       (drv.x_ack),
    .tx_exc_arb_i       (drv.x_arb),
    .tx_flag_biterr_i   (drv.tx_fbit),
    .tx_extra_dom_i     (drv.tx_xdom),
    .tx_ok_i            (drv.tx_ok),
    .rx_ok_i            (drv.rx_ok),
    .idle11_i           (drv.idle),
    .rm_clear_i         (drv.rmclr),
    .tec_o              (tec_o),
    .rec_o              (rec_o),
    .node_state_o       (node_state_o),
    .warn_o             (warn_o),
    .reset_mode_o       (reset_mode_o),
    .busoff_irq_o       (busoff_irq_o),
    .recover_irq_o      (recover_irq_o)
  );

  // Scoreboard
  exp_t  exp_q[$];
  string tag_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;

  // Reference state, kept by the driver
  int m_tec = 0, m_rec = 0, m_cnt = 0;
  bit m_bo = 0, m_rm = 0, en_want = 0;

  function automatic exp_t predict(ev_t e, bit en);
    exp_t x;
    bit   birq = 0, rirq = 0;
    int   ti = 0, ri = 0;
    bit   pas;
    if (m_bo) begin
      if (m_rm) begin
        if (e.rmclr) m_rm = 0;
      end else if (e.idle) begin
        m_cnt++;
        if (m_cnt == 128) begin
          m_bo = 0; m_tec = 0; m_rec = 0; m_cnt = 0; rirq = en;
        end
      end
    end else begin
      pas = (m_tec >= 128) || (m_rec >= 128);
      if (e.tx_flag && !e.x_arb && !(e.x_ack && pas)) ti += 8;
      if (e.tx_fbit) ti += 8;
      if (e.tx_xdom) ti += 8;
      if (e.rx_fbit) ri += 8;
      else if (e.rx_err) ri += 1;
      if (e.rx_dom) ri += 8;
      if (e.rx_xdom) ri += 8;
      if (m_tec + ti >= 256) begin
        m_bo = 1; m_rm = 1; m_tec = 127; m_rec = 0; m_cnt = 0; birq = en;
      end else begin
        if (ti != 0) m_tec += ti;
        else if (e.tx_ok && m_tec > 0) m_tec--;
        if (ri != 0) m_rec = (m_rec + ri > 255) ? 255 : m_rec + ri;
        else if (e.rx_ok) m_rec = (m_rec > 127) ? 127 : (m_rec > 0 ? m_rec - 1 : 0);
      end
    end
    x.tec  = 9'(m_tec);
    x.rec  = 8'(m_rec);
    x.st   = m_bo ? 2'b10 : ((m_tec >= 128 || m_rec >= 128) ? 2'b01 : 2'b00);
    x.warn = (m_tec > 96) || (m_rec > 96);
    x.rm   = m_rm;
    x.birq = birq;
    x.rirq = rirq;
    return x;
  endfunction

  task automatic step(ev_t e, string tag);
    exp_t x;
    @(negedge clk);
    drv    = e;
    irq_en = en_want;
    x      = predict(e, en_want);
    @(posedge clk);
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic compare(exp_t x, string tag);
    exp_t a;
    a = '{tec: tec_o, rec: rec_o, st: node_state_o, warn: warn_o,
          rm: reset_mode_o, birq: busoff_irq_o, rirq: recover_irq_o};
    n_vec++;
    if (a !== x) begin
      n_bad++;
      $display("FAIL %s: tec=%0d rec=%0d st=%b warn=%b rm=%b birq=%b rirq=%b expected tec=%0d rec=%0d st=%b warn=%b rm=%b birq=%b rirq=%b",
               tag, a.tec, a.rec, a.st, a.warn, a.rm, a.birq, a.rirq,
               x.tec, x.rec, x.st, x.warn, x.rm, x.birq, x.rirq);
    end
  endtask

  // Monitor: pop and compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    ev_t e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    e = '0; step(e, "R1 reset state");
    e = '0; e.tx_ok = 1; step(e, "R4 floor at zero");
    e = '0; e.rx_ok = 1; step(e, "R5 floor at zero");

    for (int i = 0; i < 3; i++) begin e = '0; e.rx_err = 1; step(e, "R2 plus one"); end
    e = '0; e.rx_err = 1; e.rx_fbit = 1; step(e, "R2 flag bit error replaces one");
    e = '0; e.rx_dom = 1; step(e, "R2 dominant after flag");
    e = '0; e.rx_ok = 1; step(e, "R5 step down");

    e = '0; e.tx_flag = 1; step(e, "R3 flag plus eight");
    e = '0; e.tx_flag = 1; e.x_arb = 1; step(e, "R3 arbitration exception");
    e = '0; e.tx_flag = 1; e.x_ack = 1; step(e, "R3 ack qualifier ignored when active");
    e = '0; e.tx_ok = 1; step(e, "R4 step down");
    e = '0; e.tx_ok = 1; e.tx_flag = 1; step(e, "R6 tx decrement dropped");
    e = '0; e.rx_ok = 1; e.rx_err = 1; step(e, "R6 rx decrement dropped");

    for (int i = 0; i < 81; i++) begin e = '0; e.rx_err = 1; step(e, "R12 warning threshold"); end

    for (int i = 0; i < 10; i++) begin
      e = '0; e.rx_dom = 1; e.rx_xdom = 1; step(e, "R2 R7 saturate and passive");
    end
    e = '0; e.tx_flag = 1; e.x_ack = 1; step(e, "R3 ack exception when passive");
    e = '0; e.rx_ok = 1; step(e, "R5 clamp to 127");

    en_want = 1;
    for (int i = 0; i < 10; i++) begin
      e = '0; e.tx_flag = 1; e.tx_fbit = 1; e.tx_xdom = 1; step(e, "R3 R8 climb to bus off");
    end
    e = '0; step(e, "R8 interrupt drops");
    e = '0; e.tx_ok = 1; e.rx_err = 1; e.rx_dom = 1; e.tx_flag = 1; e.rx_ok = 1;
    step(e, "R9 events ignored");
    for (int i = 0; i < 200; i++) begin e = '0; e.idle = 1; step(e, "R10 strobes ignored"); end
    e = '0; e.rmclr = 1; step(e, "R10 reset mode cleared");
    for (int i = 0; i < 128; i++) begin e = '0; e.idle = 1; step(e, "R11 recovery count"); end
    e = '0; step(e, "R11 after recovery");

    en_want = 0;
    for (int i = 0; i < 11; i++) begin
      e = '0; e.tx_flag = 1; e.tx_fbit = 1; e.tx_xdom = 1; step(e, "R8 entry without interrupt");
    end
    e = '0; e.rmclr = 1; step(e, "R10 clear again");
    for (int i = 0; i < 128; i++) begin e = '0; e.idle = 1; step(e, "R11 recovery without interrupt"); end
    e = '0; step(e, "R1 idle");

    repeat (3) @(negedge clk);
    summary();
  end

endmodule